// File: doc/BRIEF.md
# Split-Phase SPI Register Writer

This block is a transmit-only SPI master that delivers one register write per chip-select frame to a waveform DAC. A word enters through a valid/ready handshake. The upper half is the register address and the lower half is the register value. The block drives chip select low and shifts both halves out MSB first on MOSI. The serial clock comes in two separate bursts. Quiet intervals, with SCLK held low, come after chip select falls, between the two bursts, and before chip select rises again. There is no receive path.

The input stream has back-pressure. `in_ready` is high only while no frame is in progress. A word transfers on any rising clock edge where `in_valid` and `in_ready` are both high. While a frame is running, `in_valid` is ignored and the word on `in_word` has no effect. A source may keep `in_valid` high and `in_word` stable until the transfer happens. The serial clock period and the three quiet intervals are parameters counted in system clocks.

Top module: `spi_seg_writer`

## Requirements
- R1: `in_ready` equals the inverse of `busy`. A word is accepted on a rising edge with `in_valid` and `in_ready` high. In the next cycle `cs_n` is 0 and `busy` is 1.
- R2: `in_valid` and `in_word` have no effect while `busy` is 1. The frame in progress continues unchanged, and no further frame starts for that strobe.
- R3: After acceptance, `cs_n` is low with `sclk` low for exactly LEAD_GAP cycles before the first `sclk` high cycle.
- R4: Each serial bit has `sclk` high for CLK_DIV/2 cycles followed by low for CLK_DIV/2 cycles. The first burst has ADDR_W bits and the second has DATA_W bits.
- R5: MOSI carries `in_word` MSB first, from bit ADDR_W+DATA_W-1 down to bit 0. It presents the first bit from the first cycle of the frame. It changes only in the cycle where `sclk` falls, and it never changes while `sclk` is high.
- R6: After the last address bit's low half-period, `sclk` stays low for MID_GAP more cycles. MOSI shows the first value bit during that time.
- R7: After the last value bit's low half-period, `cs_n` stays low with `sclk` and MOSI low for TAIL_GAP more cycles.
- R8: In the first cycle with `cs_n` high again, `done` is 1 for exactly one cycle and `busy` is 0. A new word may be accepted in that cycle.
- R9: Whenever `cs_n` is 1, `sclk` and `mosi` are 0.
- R10: During reset, `cs_n` is 1, `sclk`, `mosi`, `busy` and `done` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_word` is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | ADDR_W+DATA_W | Address in the upper bits, value in the lower bits |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, changes on falling `sclk` |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when chip select releases |

## Verification
The bench sends words with set bits at the extremes, such as 0x80000001. This exposes an off-by-one bit count, which would drop or duplicate the edge bits or leave MOSI high in the tail interval. It raises a second strobe in the middle of a frame with a different word; a design that took it would restart or corrupt the frame. It also holds `in_valid` high across a frame end to get back-to-back frames. Here a design that releases `ready` one cycle late, or stretches `done`, shows a wrong chip-select high width. The reference model checks every quiet interval cycle by cycle. A miscounted gap or half-period therefore shifts a clock edge and is caught in the first cycle where it differs.

// File: rtl/spi_seg_pkg.sv
`timescale 1ns/1ps
package spi_seg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ADDR,
    ST_MID,
    ST_DATA,
    ST_TAIL
  } seg_state_e;
endpackage

// File: rtl/spi_seg_sclk.sv
`timescale 1ns/1ps
// Serial clock generator: high half-period then low half-period per bit.
module spi_seg_sclk #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,        // start a burst: next cycle sclk is high
  input  logic active,    // a burst is running
  input  logic more,      // further bits remain in the burst
  output logic sclk,
  output logic fall_now,  // this edge ends a high half-period
  output logic low_end    // this edge ends a low half-period
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] ph;
  logic          sclk_q;
  logic          ph_last;

  assign ph_last  = (ph == PW'(HALF - 1));
  assign fall_now = active && sclk_q && ph_last;
  assign low_end  = active && !sclk_q && ph_last;
  assign sclk     = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ph     <= '0;
    end else if (go) begin
      sclk_q <= 1'b1;
      ph     <= '0;
    end else if (active) begin
      if (ph_last) begin
        ph     <= '0;
        sclk_q <= sclk_q ? 1'b0 : more;
      end else begin
        ph <= ph + 1'b1;
      end
    end else begin
      sclk_q <= 1'b0;
      ph     <= '0;
    end
  end
endmodule

// File: rtl/spi_seg_shift.sv
`timescale 1ns/1ps
// MSB-first shift register; zero fill so MOSI returns low after the last bit.
module spi_seg_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         mosi
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= word;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign mosi = sr[W-1];
endmodule

// File: rtl/spi_seg_seq.sv
`timescale 1ns/1ps
// Frame sequencer: quiet intervals, burst bit counting, chip select, done.
module spi_seg_seq
  import spi_seg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LEAD_GAP = 3,
  parameter int MID_GAP  = 5,
  parameter int TAIL_GAP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       fall_now,
  input  logic       low_end,
  output seg_state_e state,
  output logic       go,
  output logic       active,
  output logic       more,
  output logic       cs_n,
  output logic       done
);
  localparam int GMAX0 = (LEAD_GAP > MID_GAP) ? LEAD_GAP : MID_GAP;
  localparam int GMAX  = (GMAX0 > TAIL_GAP) ? GMAX0 : TAIL_GAP;
  localparam int GW    = $clog2(GMAX + 1);
  localparam int BMAX  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int BW    = $clog2(BMAX + 1);

  logic [GW-1:0] gap_cnt;
  logic [GW-1:0] gap_limit;
  logic          gap_last;
  logic [BW-1:0] bit_cnt;
  logic [BW-1:0] bit_limit;

  always_comb begin
    case (state)
      ST_LEAD: gap_limit = GW'(LEAD_GAP - 1);
      ST_MID:  gap_limit = GW'(MID_GAP - 1);
      default: gap_limit = GW'(TAIL_GAP - 1);
    endcase
  end

  assign gap_last  = (gap_cnt == gap_limit);
  assign go        = ((state == ST_LEAD) || (state == ST_MID)) && gap_last;
  assign active    = (state == ST_ADDR) || (state == ST_DATA);
  assign bit_limit = (state == ST_ADDR) ? BW'(ADDR_W) : BW'(DATA_W);
  assign more      = (bit_cnt != bit_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gap_cnt <= '0;
      bit_cnt <= '0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_LEAD;
          cs_n    <= 1'b0;
          gap_cnt <= '0;
        end
        ST_LEAD, ST_MID: if (gap_last) begin
          state   <= (state == ST_LEAD) ? ST_ADDR : ST_DATA;
          bit_cnt <= '0;
          gap_cnt <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        ST_ADDR, ST_DATA: begin
          if (fall_now) bit_cnt <= bit_cnt + 1'b1;
          if (low_end && !more) begin
            state   <= (state == ST_ADDR) ? ST_MID : ST_TAIL;
            gap_cnt <= '0;
          end
        end
        ST_TAIL: if (gap_last) begin
          state   <= ST_IDLE;
          cs_n    <= 1'b1;
          done    <= 1'b1;
          gap_cnt <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seg_writer.sv
`timescale 1ns/1ps
// Top: one register write per chip-select frame, split into two bursts.
module spi_seg_writer
  import spi_seg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_DIV  = 4,   // even, >= 2
  parameter int LEAD_GAP = 3,   // >= 1
  parameter int MID_GAP  = 5,   // >= 1
  parameter int TAIL_GAP = 2    // >= 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ADDR_W+DATA_W-1:0] in_word,
  output logic                     sclk,
  output logic                     mosi,
  output logic                     cs_n,
  output logic                     busy,
  output logic                     done
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int WORD_W = ADDR_W + DATA_W;

  seg_state_e state;
  logic       accept;
  logic       go;
  logic       active;
  logic       more;
  logic       fall_now;
  logic       low_end;

  assign busy     = (state != ST_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  spi_seg_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LEAD_GAP(LEAD_GAP), .MID_GAP(MID_GAP), .TAIL_GAP(TAIL_GAP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .fall_now(fall_now), .low_end(low_end),
    .state(state), .go(go), .active(active), .more(more),
    .cs_n(cs_n), .done(done)
  );

  spi_seg_sclk #(.HALF(HALF)) u_sclk (
    .clk(clk), .rst_n(rst_n), .go(go), .active(active), .more(more),
    .sclk(sclk), .fall_now(fall_now), .low_end(low_end)
  );

  spi_seg_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(in_word),
    .shift(fall_now), .mosi(mosi)
  );
endmodule

// File: rtl/spi_seg_writer_chk.sv
`timescale 1ns/1ps
module spi_seg_writer_chk #(
  parameter int CLK_DIV  = 4,
  parameter int LEAD_GAP = 3,
  parameter int TAIL_GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done
);
  localparam int HALF = CLK_DIV / 2;

  logic [15:0] cs_age;
  logic [15:0] hi_run;
  logic [15:0] lo_run;
  logic        seen_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_age    <= '0;
      hi_run    <= '0;
      lo_run    <= '0;
      seen_rise <= 1'b0;
    end else begin
      cs_age    <= cs_n ? 16'd0 : ((cs_age == 16'hFFFF) ? cs_age : cs_age + 16'd1);
      hi_run    <= !sclk ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1);
      lo_run    <= (cs_n || sclk) ? 16'd0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1);
      seen_rise <= cs_n ? 1'b0 : (seen_rise || sclk);
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!cs_n && busy));

  p_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && !seen_rise) |-> (cs_age == 16'(LEAD_GAP)));

  p_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == 16'(HALF)));

  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  p_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (lo_run == 16'(HALF + TAIL_GAP)));

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy && !$past(cs_n)));

  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !mosi));
endmodule

bind spi_seg_writer spi_seg_writer_chk #(
  .CLK_DIV(CLK_DIV), .LEAD_GAP(LEAD_GAP), .TAIL_GAP(TAIL_GAP)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
);

// File: tb/test_spi_seg_writer.sv
`timescale 1ns/1ps
module test_spi_seg_writer;
  localparam int AW = 16, DW = 16, WW = AW + DW;
  localparam int DIV = 4, HALF = DIV / 2, LEAD = 3, MID = 5, TAIL = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic          in_ready, sclk, mosi, cs_n, busy, done;

  spi_seg_writer #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_DIV(DIV),
    .LEAD_GAP(LEAD), .MID_GAP(MID), .TAIL_GAP(TAIL)
  ) i_spi_seg_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit run_model = 1'b0;
  bit spurious = 1'b0;

  // expected per-cycle outputs
  bit qc[$], qs[$], qm[$], qb[$], qd[$];
  int qt[$];

  function automatic string tagname(int t);
    case (t)
      1: return "R1";
      3: return "R3";
      4: return "R4";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic void push(bit c, bit s, bit m, bit b, bit d, int t);
    qc.push_back(c); qs.push_back(s); qm.push_back(m);
    qb.push_back(b); qd.push_back(d); qt.push_back(t);
  endfunction

  // Behavioural frame expectation from the requirements
  function automatic void build(logic [WW-1:0] w);
    for (int i = 0; i < LEAD; i++) push(0, 0, w[WW-1], 1, 0, (i == 0) ? 1 : 3);
    for (int idx = WW - 1; idx >= 0; idx--) begin
      for (int h = 0; h < HALF; h++) push(0, 1, w[idx], 1, 0, 4);
      for (int h = 0; h < HALF; h++) push(0, 0, (idx > 0) ? w[idx-1] : 1'b0, 1, 0, 4);
      if (idx == DW)
        for (int g = 0; g < MID; g++) push(0, 0, w[DW-1], 1, 0, 6);
    end
    for (int g = 0; g < TAIL; g++) push(0, 0, 0, 1, 0, 7);
    push(1, 0, 0, 0, 1, 8);
  endfunction

  always @(negedge clk) begin
    if (rst_n && run_model) begin
      bit ec, es, em, eb, ed;
      int et;
      if (qc.size() > 0) begin
        ec = qc.pop_front(); es = qs.pop_front(); em = qm.pop_front();
        eb = qb.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
      end else begin
        ec = 1; es = 0; em = 0; eb = 0; ed = 0; et = 9;
      end
      checks++;
      if ({cs_n, sclk, mosi, busy, done, in_ready} !== {ec, es, em, eb, ed, !eb}) begin
        errors++;
        $display("FAIL %s%s t=%0t actual cs_n=%b sclk=%b mosi=%b busy=%b done=%b ready=%b expected %b %b %b %b %b %b",
                 (mosi !== em) ? "R5" : tagname(et), spurious ? " R2" : "", $time,
                 cs_n, sclk, mosi, busy, done, in_ready, ec, es, em, eb, ed, !eb);
      end
      if (in_valid && !eb) build(in_word);
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic send(logic [WW-1:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1; in_word = w;
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual frame never completed, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: reset values
    checks++;
    if ({cs_n, sclk, mosi, busy, done, in_ready} !== 6'b100001) begin
      errors++;
      $display("FAIL R10 actual %b%b%b%b%b%b expected 100001",
               cs_n, sclk, mosi, busy, done, in_ready);
    end
    @(posedge clk); #1;
    rst_n = 1'b1; run_model = 1'b1;
    repeat (3) @(posedge clk);

    send(32'hA5C3_0F96);   // R3 R4 R5 R6 R7: mixed pattern
    send(32'h8000_0001);   // R5: extreme bits
    send(32'hFFFF_FFFF);   // R7: MOSI must drop in tail
    send(32'h0001_8000);   // R6: bits adjacent to the split

    // R2: strobe with another word during a frame is ignored
    @(posedge clk); #1;
    in_valid = 1'b1; in_word = 32'h1234_5678;
    @(posedge clk); #1;
    in_word = 32'hDEAD_BEEF; spurious = 1'b1;
    repeat (20) @(posedge clk);
    #1 in_valid = 1'b0;
    wait_idle();
    spurious = 1'b0;

    // R1 R8: valid held across frame end -> back-to-back frames
    @(posedge clk); #1;
    in_valid = 1'b1; in_word = 32'h0F0F_F0F0;
    @(posedge clk);
    do @(negedge clk); while (!done);
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_idle();

    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule